// File: doc/BRIEF.md
# Eight-Channel Dual-Match Down-Counter Timer

This block is a bank of independent down-counting timers behind a simple word-addressed register bus. Each channel has a counter, a reload value and two match thresholds. It counts either a shared prescaled tick taken from the system clock or an external tick input. When the count runs out, the counter reloads itself. An event is raised when the count steps onto an active match threshold. An event can also be raised when the count runs out, if the channel's zero-event enable is set or if one of its thresholds is inactive.

An event does not pulse the channel's interrupt line. It inverts the line's level and sets the channel's sticky bit in a status register, and software clears that bit by writing 1 to it. A shared control register holds four configuration bits per channel. A companion clear register lets software drop individual control bits without a read-modify-write. Reads complete in the same cycle. Writes take effect at the next clock edge.

Top module: `mtb_timer_bank`

## Requirements
- R1: After reset, every counter, reload, match, control and status register reads 0, and every `irq_o` bit is 0.
- R2: Channel slots are 16 bytes wide. Channels 0–2 sit at 0x00, 0x10 and 0x20, and channels 3–7 sit at 0x40 through 0x80. Inside a slot, +0x0 is the counter, +0x4 is reload, +0x8 is match A and +0xC is match B. Control is at 0x30, status at 0x34 and control-clear at 0x3C. Any other offset reads 0, and writes to it change nothing.
- R3: The control bits for channel i are bits [4i+3:4i]. Bit 4i is enable, 4i+1 selects the external tick, 4i+2 is the zero-event enable and 4i+3 is the pulse-mode flag, which is only stored. A write to control-clear (0x3C) clears each control bit written as 1.
- R4: While a channel is disabled, its counter holds and reads back the reload value. Setting enable loads the counter from reload.
- R5: An enabled channel with nonzero reload counts down by 1 on each selected tick. The selected tick is `ext_tick_i` when the select bit is 1. Otherwise it is the internal tick, which fires once every PRESCALE clocks.
- R6: A tick taken at count 1 (or 0) is the zero point. The counter reloads there, and an event fires if the zero-event enable is 1 or if either effective match is 0.
- R7: A match register is effective only when it is below reload; otherwise it counts as 0. A tick that moves the count onto a nonzero effective match fires an event.
- R8: Each event inverts that channel's `irq_o` bit. Without an event, the bit holds.
- R9: Each event sets the channel's status bit (bit i of 0x34). Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R10: Writing the counter offset of an enabled channel replaces the count and leaves reload unchanged.
- R11: An enabled channel with reload 0 holds its count and raises no event. Writing a nonzero reload to it starts it from the written value.
- R12: Writing a new nonzero reload over a nonzero one while the channel runs leaves the current count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| ext_tick_i | input | 1 | External tick, one count per high cycle |
| irq_o | output | N_TIMERS | Per-channel toggling interrupt level |

## Verification
The bench uses the default eight channels and 32-bit data, which places channels on both sides of the control block in the address map. PRESCALE is set to 3, so the internal tick can be told apart from the clock and counted over a short window. Most scenarios select the external tick, which lets a task step a channel one count at a time. That makes the match crossings, the zero point, the gating by effective match and the write-over-count cases land on known cycles.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic pulse;  // stored only
    logic zie;    // zero-event enable
    logic ext;    // external tick select
    logic en;
  } cfg_t;

  localparam logic [7:0] CTRL_ADDR  = 8'h30;
  localparam logic [7:0] STS_ADDR   = 8'h34;
  localparam logic [7:0] CCLR_ADDR  = 8'h3C;
  localparam int         CTRL_SLOT  = 3;

  localparam logic [1:0] FLD_CNT = 2'd0;
  localparam logic [1:0] FLD_REL = 2'd1;
  localparam logic [1:0] FLD_MA  = 2'd2;
  localparam logic [1:0] FLD_MB  = 2'd3;

  // channels skip the slot holding control/status
  function automatic int slot_of(int idx);
    return (idx < CTRL_SLOT) ? idx : idx + 1;
  endfunction
endpackage

// File: rtl/mtb_prescaler.sv
module mtb_prescaler #(
  parameter int DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (DIV <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R5
  end
endmodule

// File: rtl/mtb_channel.sv
module mtb_channel
  import mtb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_tick_i,
  input  logic              ext_tick_i,
  input  cfg_t              cfg_i,
  input  logic              wr_cnt_i,
  input  logic              wr_rel_i,
  input  logic              wr_ma_i,
  input  logic              wr_mb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] rel_o,
  output logic [DATA_W-1:0] ma_o,
  output logic [DATA_W-1:0] mb_o,
  output logic              evt_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, rel_q, ma_q, mb_q, ma_eff, mb_eff, nxt;
  logic en_q, lvl_q, tick, running, step, at_end, zero_evt, match_evt;

  assign tick    = cfg_i.ext ? ext_tick_i : pre_tick_i;
  assign running = cfg_i.en & en_q & (rel_q != '0);
  assign step    = running & tick & ~wr_cnt_i;
  assign at_end  = (cnt_q <= DATA_W'(1));
  assign nxt     = cnt_q - 1'b1;

  assign ma_eff = (ma_q < rel_q) ? ma_q : '0;
  assign mb_eff = (mb_q < rel_q) ? mb_q : '0;

  assign zero_evt  = step & at_end &
                     (cfg_i.zie | (ma_eff == '0) | (mb_eff == '0));
  assign match_evt = step & ~at_end &
                     (((ma_eff != '0) & (nxt == ma_eff)) |
                      ((mb_eff != '0) & (nxt == mb_eff)));
  assign evt_o = zero_evt | match_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
      en_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      en_q <= cfg_i.en;
      if (evt_o) lvl_q <= ~lvl_q;
      if (wr_rel_i) rel_q <= wdata_i;
      if (wr_ma_i)  ma_q  <= wdata_i;
      if (wr_mb_i)  mb_q  <= wdata_i;

      if (cfg_i.en && !en_q)
        cnt_q <= rel_q;
      else if (wr_cnt_i && cfg_i.en)
        cnt_q <= wdata_i;
      else if (wr_rel_i && cfg_i.en && rel_q == '0 && wdata_i != '0)
        cnt_q <= wdata_i;
      else if (step)
        cnt_q <= at_end ? rel_q : nxt;
    end
  end

  assign cnt_o = (cfg_i.en & en_q) ? cnt_q : rel_q;
  assign rel_o = rel_q;
  assign ma_o  = ma_q;
  assign mb_o  = mb_q;
  assign irq_o = lvl_q;

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> cnt_q == $past(cnt_q)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !at_end && !wr_rel_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(irq_o)); // R8
  AST_START_ON_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rel_i && cfg_i.en && en_q && rel_q == '0 && wdata_i != '0)
      |=> cnt_q == $past(wdata_i)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q == '0) |-> !evt_o); // R11
endmodule

// File: rtl/mtb_timer_bank.sv
module mtb_timer_bank
  import mtb_pkg::*;
#(
  parameter int N_TIMERS = 8,   // at most 8: control fits one data word
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                ext_tick_i,
  output logic [N_TIMERS-1:0] irq_o
);
  localparam int CTRL_W = N_TIMERS * CFG_W;
  localparam int SLOT_W = ADDR_W - 4;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [N_TIMERS-1:0] sts_q, evt, clr_mask;
  logic                pre_tick, hit_ctrl, hit_sts, hit_cclr;
  logic [N_TIMERS-1:0] hit_slot;
  logic [DATA_W-1:0]   cnt_rb [N_TIMERS];
  logic [DATA_W-1:0]   rel_rb [N_TIMERS];
  logic [DATA_W-1:0]   ma_rb  [N_TIMERS];
  logic [DATA_W-1:0]   mb_rb  [N_TIMERS];

  assign hit_ctrl = ({addr_i[ADDR_W-1:2], 2'b00} == ADDR_W'(CTRL_ADDR));
  assign hit_sts  = ({addr_i[ADDR_W-1:2], 2'b00} == ADDR_W'(STS_ADDR));
  assign hit_cclr = ({addr_i[ADDR_W-1:2], 2'b00} == ADDR_W'(CCLR_ADDR));

  mtb_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
    localparam int SLOT = slot_of(i);
    logic sel;
    assign sel = (addr_i[ADDR_W-1:4] == SLOT_W'(SLOT));
    assign hit_slot[i] = sel;

    mtb_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pre_tick_i (pre_tick),
      .ext_tick_i (ext_tick_i),
      .cfg_i      (cfg_t'(ctrl_q[i*CFG_W +: CFG_W])),
      .wr_cnt_i   (we_i & sel & (addr_i[3:2] == FLD_CNT)),
      .wr_rel_i   (we_i & sel & (addr_i[3:2] == FLD_REL)),
      .wr_ma_i    (we_i & sel & (addr_i[3:2] == FLD_MA)),
      .wr_mb_i    (we_i & sel & (addr_i[3:2] == FLD_MB)),
      .wdata_i    (wdata_i),
      .cnt_o      (cnt_rb[i]),
      .rel_o      (rel_rb[i]),
      .ma_o       (ma_rb[i]),
      .mb_o       (mb_rb[i]),
      .evt_o      (evt[i]),
      .irq_o      (irq_o[i])
    );

    AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[i] |=> sts_q[i]); // R9
  end

  assign clr_mask = (we_i & hit_sts) ? wdata_i[N_TIMERS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sts_q  <= '0;
    end else begin
      if (we_i && hit_ctrl)      ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (we_i && hit_cclr) ctrl_q <= ctrl_q & ~wdata_i[CTRL_W-1:0];
      sts_q <= (sts_q & ~clr_mask) | evt;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) rdata_o = DATA_W'(ctrl_q);
    else if (hit_sts) rdata_o = DATA_W'(sts_q);
    for (int i = 0; i < N_TIMERS; i++) begin
      if (hit_slot[i]) begin
        case (addr_i[3:2])
          FLD_CNT: rdata_o = cnt_rb[i];
          FLD_REL: rdata_o = rel_rb[i];
          FLD_MA:  rdata_o = ma_rb[i];
          default: rdata_o = mb_rb[i];
        endcase
      end
    end
  end

  AST_CCLR_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_cclr) |=> (ctrl_q & ~$past(ctrl_q)) == '0); // R3
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask != '0 && evt == '0) |=> (sts_q & $past(clr_mask)) == '0); // R9
endmodule

// File: tb/mtb_timer_bank_test.sv
module mtb_timer_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_tick = 1'b0;
  logic [NT-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtb_timer_bank #(.N_TIMERS(NT), .DATA_W(32), .ADDR_W(8), .PRESCALE(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_tick_i(ext_tick), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    check("R1 irq", 32'(irq), 32'h0);
    chk_rd("R1 cnt0", 8'h00, 0);
    chk_rd("R1 rel0", 8'h04, 0);
    chk_rd("R1 ma0", 8'h08, 0);
    chk_rd("R1 mb7", 8'h8C, 0);
    chk_rd("R1 ctrl", 8'h30, 0);
    chk_rd("R1 sts", 8'h34, 0);
  endtask

  task automatic t_map();
    wr(8'h44, 32'h1234);
    wr(8'h48, 32'h0055);
    wr(8'h4C, 32'h0066);
    chk_rd("R2 ch3 reload", 8'h44, 32'h1234);
    chk_rd("R2 ch3 matchA", 8'h48, 32'h0055);
    chk_rd("R2 ch3 matchB", 8'h4C, 32'h0066);
    chk_rd("R2 ch3 counter shows reload", 8'h40, 32'h1234);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h90, 32'hFFFF_FFFF);
    chk_rd("R2 unmapped 0x38", 8'h38, 0);
    chk_rd("R2 unmapped 0x90", 8'h90, 0);
    chk_rd("R2 ctrl untouched", 8'h30, 0);
    chk_rd("R2 sts untouched", 8'h34, 0);
    chk_rd("R2 ch2 reload untouched", 8'h24, 0);
  endtask

  task automatic t_enable();
    wr(8'h04, 32'd10);
    tick();
    chk_rd("R4 disabled reads reload", 8'h00, 32'd10);
    wr(8'h30, 32'h3);
    chk_rd("R4 enabled loads reload", 8'h00, 32'd10);
    tick(); tick(); tick();
    chk_rd("R5 three ext ticks", 8'h00, 32'd7);
    wr(8'h30, 32'h0);
    chk_rd("R4 disable shows reload", 8'h00, 32'd10);
    tick();
    wr(8'h30, 32'h3);
    chk_rd("R4 re-enable reloads", 8'h00, 32'd10);
    tick();
    chk_rd("R5 counts after re-enable", 8'h00, 32'd9);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_zero();
    wr(8'h14, 32'd4);
    wr(8'h18, 32'd2);
    wr(8'h1C, 32'd2);
    wr(8'h30, 32'h30);
    tick();
    check("R8 no event yet", 32'(irq[1]), 0);
    tick();
    chk_rd("R7 count at match", 8'h10, 32'd2);
    check("R7 match toggles irq", 32'(irq[1]), 1);
    tick();
    check("R8 irq holds", 32'(irq[1]), 1);
    tick();
    chk_rd("R6 reload at zero point", 8'h10, 32'd4);
    check("R6 no zero event without enable", 32'(irq[1]), 1);
    wr(8'h30, 32'h70);
    tick(); tick();
    check("R8 second match toggles back", 32'(irq[1]), 0);
    tick(); tick();
    check("R6 zero event with enable", 32'(irq[1]), 1);
    chk_rd("R9 status bit set", 8'h34, 32'h2);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    chk_rd("R9 write 0 keeps status", 8'h34, 32'h2);
    wr(8'h34, 32'h2);
    chk_rd("R9 write 1 clears status", 8'h34, 32'h0);
    check("R9 clear leaves irq level", 32'(irq[1]), 1);
  endtask

  task automatic t_eff_match();
    wr(8'h24, 32'd3);
    wr(8'h28, 32'd3);
    wr(8'h2C, 32'd7);
    wr(8'h30, 32'h300);
    tick(); tick();
    check("R7 out-of-range match inert", 32'(irq[2]), 0);
    tick();
    check("R6 zero event from inactive match", 32'(irq[2]), 1);
    chk_rd("R6 reloaded", 8'h20, 32'd3);
    wr(8'h28, 32'd1);
    tick(); tick();
    check("R7 valid match fires", 32'(irq[2]), 0);
    tick();
    check("R6 matchB inactive forces zero event", 32'(irq[2]), 1);
    chk_rd("R9 status ch2", 8'h34, 32'h4);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'hFF);
  endtask

  task automatic t_writes();
    logic [31:0] d;
    wr(8'h04, 32'd20);
    wr(8'h30, 32'h3);
    tick();
    chk_rd("R5 ch0 19", 8'h00, 32'd19);
    wr(8'h00, 32'd5);
    chk_rd("R10 counter written", 8'h00, 32'd5);
    chk_rd("R10 reload kept", 8'h04, 32'd20);
    tick();
    chk_rd("R10 counts from written", 8'h00, 32'd4);
    wr(8'h04, 32'd30);
    chk_rd("R12 count kept on reload change", 8'h00, 32'd4);
    chk_rd("R12 new reload", 8'h04, 32'd30);
    wr(8'h30, 32'h0);
    wr(8'h04, 32'd0);
    wr(8'h30, 32'h3);
    d = 32'(irq[0]);
    tick(); tick();
    chk_rd("R11 zero reload holds", 8'h00, 32'd0);
    check("R11 no event at zero reload", 32'(irq[0]), d);
    chk_rd("R11 no status", 8'h34, 32'h0);
    wr(8'h04, 32'd6);
    chk_rd("R11 start on reload", 8'h00, 32'd6);
    tick();
    chk_rd("R11 running", 8'h00, 32'd5);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(8'h30, 32'h0000_0F0B);
    chk_rd("R3 ctrl readback", 8'h30, 32'h0000_0F0B);
    wr(8'h3C, 32'h0000_0103);
    chk_rd("R3 ctrl clear", 8'h30, 32'h0000_0E08);
    chk_rd("R3 clear reg reads 0", 8'h3C, 32'h0);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v0, v1;
    wr(8'h64, 32'd100);
    wr(8'h30, 32'h0010_0000);
    repeat (2) @(negedge clk);
    rd(8'h60, v0);
    n_chk++;
    if (v0 != 32'd100 && v0 != 32'd99) begin
      n_fail++;
      $display("FAIL R5 prescaled start: actual %0d expected 100 or 99", v0);
    end
    repeat (9) @(negedge clk);
    rd(8'h60, v1);
    check("R5 three internal ticks in nine clocks", v0 - v1, 32'd3);
    tick();
    rd(8'h60, v0);
    check("R5 ext tick ignored when not selected", v1 - v0 <= 1 ? 32'd1 : 32'd0, 32'd1);
    wr(8'h30, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_enable();
    t_zero();
    t_eff_match();
    t_writes();
    t_ctrl();
    t_prescale();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule